// File: doc/BRIEF.md
# Trigger Counter/Timer Pair

This block holds a small bank of wide counter/timers (two by default, 51 bits each) that a trigger sequencer drives one command at a time. Each unit has a mode pin. In counting mode the count moves up or down one step on each commanded cycle. In timing mode the count advances on every clock while the unit is running, and start and stop commands switch it on and off. Every unit can be cleared or loaded with a value. It also raises a test flag whenever its count is at or above a programmable threshold.

The clear path has no latency. In the cycle where a clear is asserted, the count output already reads zero and the test flag is judged against zero, so a sequencer state that clears and tests in the same cycle sees the cleared value. Clearing a timer leaves its running or halted condition as it was. The count saturates at both ends of its range instead of wrapping. A sticky overflow flag records that a unit has saturated.

All pins are plain control and status signals. The block has no streaming interface, so no valid/ready back-pressure applies.

Top module: `trig_ctr_pair`

## Requirements
- R1: After the asynchronous active-low reset, every unit reads count 0 and overflow 0, and every unit is halted.
- R2: In counting mode (mode pin 0), a cycle with the up command adds one to the count at the next edge. A cycle with the down command subtracts one. With no command the count holds. Start and stop have no effect in this mode.
- R3: In timing mode (mode pin 1), start makes the unit run from the next edge and stop halts it from the next edge. A running unit adds one to its count on every cycle, and a halted unit holds its count. Up and down have no effect in this mode.
- R4: The count never wraps. A step up from the all-ones value leaves all ones, and a step down from zero leaves zero. Either case sets the overflow flag, which stays set until a clear command or the reset.
- R5: The test flag is 1 exactly when the count output is greater than or equal to the unit's compare input, treating both as unsigned. It follows a change of the compare input in the same cycle.
- R6: While clear is asserted, the count output reads zero in that same cycle and the test flag is judged against zero. The count register is zero after the edge, and the overflow flag is cleared.
- R7: A clear does not change whether a timing-mode unit is running: a running unit keeps counting from zero, and a halted one stays at zero.
- R8: The set command loads the unit's load input at the next edge. It leaves the running condition and the overflow flag unchanged.
- R9: When commands coincide in one cycle, only the highest-ranked one acts. The ranking is clear, then set, then the step (up before down in counting mode, or the running tick in timing mode), then stop before start. A set or clear also suppresses start, stop and the running tick for that cycle.
- R10: The units are independent: commands to one unit never change another unit's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | NUM_UNITS | Per-unit mode: 0 counting, 1 timing |
| clr_i | input | NUM_UNITS | Per-unit zero-latency clear |
| set_i | input | NUM_UNITS | Per-unit load of load_i |
| inc_i | input | NUM_UNITS | Per-unit step up (counting mode) |
| dec_i | input | NUM_UNITS | Per-unit step down (counting mode) |
| start_i | input | NUM_UNITS | Per-unit run (timing mode) |
| stop_i | input | NUM_UNITS | Per-unit halt (timing mode) |
| load_i | input | NUM_UNITS x CNT_W | Per-unit load value |
| cmp_i | input | NUM_UNITS x CNT_W | Per-unit compare threshold |
| count_o | output | NUM_UNITS x CNT_W | Per-unit count as seen this cycle |
| test_o | output | NUM_UNITS | Per-unit count >= threshold |
| ovf_o | output | NUM_UNITS | Per-unit sticky saturation flag |

## Verification
The bench uses 4-bit units and walks the whole count range in both directions, pushing one step past each end. A unit that wrapped would show 0 or 15 with no overflow. A flag that was not sticky would drop on the next command. Every count value is paired with every threshold, which exposes an off-by-one or signed comparison in the test flag. Clears are sampled before the clock edge: a registered clear would show the old count for one cycle. Clears of running and halted timers show whether the running condition survives. Coinciding commands show any wrong ranking, such as a start that was not suppressed by a set.

// File: rtl/trig_ctr_pkg.sv
package trig_ctr_pkg;

  typedef enum logic {
    CT_COUNT = 1'b0,
    CT_TIME  = 1'b1
  } ct_mode_e;

  // One-hot-ish action set chosen by the command ranking for one cycle.
  typedef struct packed {
    logic clear;
    logic load;
    logic up;
    logic down;
    logic run_on;
    logic run_off;
  } ct_act_t;

endpackage

// File: rtl/ct_cmd_arb.sv
module ct_cmd_arb
  import trig_ctr_pkg::*;
(
  input  ct_mode_e mode,
  input  logic     clr,
  input  logic     set,
  input  logic     inc,
  input  logic     dec,
  input  logic     start,
  input  logic     stop,
  input  logic     run_q,
  output ct_act_t  act
);

  always_comb begin
    act = '0;
    if (clr) begin
      act.clear = 1'b1;
    end else if (set) begin
      act.load = 1'b1;
    end else if (mode == CT_COUNT) begin
      if (inc)      act.up   = 1'b1;
      else if (dec) act.down = 1'b1;
    end else begin
      act.up = run_q;
      if (stop)       act.run_off = 1'b1;
      else if (start) act.run_on  = 1'b1;
    end
  end

endmodule

// File: rtl/ct_sat_step.sv
module ct_sat_step #(
  parameter int W = 51
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] nxt,
  output logic         hit
);

  logic at_top;
  logic at_bot;

  assign at_top = &cur;
  assign at_bot = ~|cur;

  always_comb begin
    nxt = cur;
    hit = 1'b0;
    if (up) begin
      if (at_top) hit = 1'b1;
      else        nxt = cur + W'(1);
    end else if (down) begin
      if (at_bot) hit = 1'b1;
      else        nxt = cur - W'(1);
    end
  end

endmodule

// File: rtl/ct_unit.sv
module ct_unit
  import trig_ctr_pkg::*;
#(
  parameter int W = 51
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ct_mode_e     mode,
  input  logic         clr,
  input  logic         set,
  input  logic         inc,
  input  logic         dec,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] load,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] view,
  output logic         tst,
  output logic         ovf
);

  logic [W-1:0] count_q;
  logic [W-1:0] step_nxt;
  logic         step_hit;
  logic         run_q;
  logic         ovf_q;
  ct_act_t      act;

  ct_cmd_arb u_arb (
    .mode  (mode),
    .clr   (clr),
    .set   (set),
    .inc   (inc),
    .dec   (dec),
    .start (start),
    .stop  (stop),
    .run_q (run_q),
    .act   (act)
  );

  ct_sat_step #(.W(W)) u_step (
    .cur  (count_q),
    .up   (act.up),
    .down (act.down),
    .nxt  (step_nxt),
    .hit  (step_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (act.clear) begin
        count_q <= '0;
        ovf_q   <= 1'b0;
      end else if (act.load) begin
        count_q <= load;
      end else begin
        count_q <= step_nxt;
        if (step_hit) ovf_q <= 1'b1;
      end
      if (act.run_on)       run_q <= 1'b1;
      else if (act.run_off) run_q <= 1'b0;
    end
  end

  // Clear is visible in the same cycle it is asserted.
  assign view = act.clear ? '0 : count_q;
  assign tst  = (view >= cmp);
  assign ovf  = ovf_q;

endmodule

// File: rtl/trig_ctr_pair.sv
module trig_ctr_pair
  import trig_ctr_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int CNT_W     = 51
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_UNITS-1:0]            mode_i,
  input  logic [NUM_UNITS-1:0]            clr_i,
  input  logic [NUM_UNITS-1:0]            set_i,
  input  logic [NUM_UNITS-1:0]            inc_i,
  input  logic [NUM_UNITS-1:0]            dec_i,
  input  logic [NUM_UNITS-1:0]            start_i,
  input  logic [NUM_UNITS-1:0]            stop_i,
  input  logic [NUM_UNITS-1:0][CNT_W-1:0] load_i,
  input  logic [NUM_UNITS-1:0][CNT_W-1:0] cmp_i,
  output logic [NUM_UNITS-1:0][CNT_W-1:0] count_o,
  output logic [NUM_UNITS-1:0]            test_o,
  output logic [NUM_UNITS-1:0]            ovf_o
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    ct_unit #(.W(CNT_W)) u_unit (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (ct_mode_e'(mode_i[u])),
      .clr   (clr_i[u]),
      .set   (set_i[u]),
      .inc   (inc_i[u]),
      .dec   (dec_i[u]),
      .start (start_i[u]),
      .stop  (stop_i[u]),
      .load  (load_i[u]),
      .cmp   (cmp_i[u]),
      .view  (count_o[u]),
      .tst   (test_o[u]),
      .ovf   (ovf_o[u])
    );
  end

endmodule

// File: rtl/trig_ctr_pair_chk.sv
module trig_ctr_pair_chk #(
  parameter int NUM_UNITS = 2,
  parameter int CNT_W     = 51
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_UNITS-1:0]            mode_i,
  input logic [NUM_UNITS-1:0]            clr_i,
  input logic [NUM_UNITS-1:0]            set_i,
  input logic [NUM_UNITS-1:0]            inc_i,
  input logic [NUM_UNITS-1:0]            dec_i,
  input logic [NUM_UNITS-1:0]            start_i,
  input logic [NUM_UNITS-1:0]            stop_i,
  input logic [NUM_UNITS-1:0][CNT_W-1:0] load_i,
  input logic [NUM_UNITS-1:0][CNT_W-1:0] cmp_i,
  input logic [NUM_UNITS-1:0][CNT_W-1:0] count_o,
  input logic [NUM_UNITS-1:0]            test_o,
  input logic [NUM_UNITS-1:0]            ovf_o
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    // R2
    count_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[u] && inc_i[u] && !clr_i[u] && !set_i[u] && !(&count_o[u]))
      |=> (clr_i[u] || count_o[u] == $past(count_o[u]) + CNT_W'(1)));

    // R4
    top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[u] && inc_i[u] && !clr_i[u] && !set_i[u] && (&count_o[u]))
      |=> (ovf_o[u] && (clr_i[u] || (&count_o[u]))));

    // R4
    bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[u] && dec_i[u] && !inc_i[u] && !clr_i[u] && !set_i[u] && (count_o[u] == '0))
      |=> (ovf_o[u] && count_o[u] == '0));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o[u] && !clr_i[u]) |=> ovf_o[u]);

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[u] && !clr_i[u]) |=> (clr_i[u] || count_o[u] == $past(load_i[u])));

    // R6
    clear_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[u] |=> !ovf_o[u]);
  end

endmodule

bind trig_ctr_pair trig_ctr_pair_chk #(
  .NUM_UNITS (NUM_UNITS),
  .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/trig_ctr_pair_bench.sv
`timescale 1ns/1ps
module trig_ctr_pair_bench;

  localparam int N    = 2;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      mode_i = '0;
  logic [N-1:0]      clr_i = '0, set_i = '0, inc_i = '0, dec_i = '0;
  logic [N-1:0]      start_i = '0, stop_i = '0;
  logic [N-1:0][W-1:0] load_i = '0, cmp_i = '0;
  logic [N-1:0][W-1:0] count_o;
  logic [N-1:0]      test_o, ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt [N];
  bit m_run [N];
  bit m_ovf [N];

  always #4 clk = ~clk;

  trig_ctr_pair #(.NUM_UNITS(N), .CNT_W(W)) u_trig_ctr_pair (
    .clk, .rst_n, .mode_i, .clr_i, .set_i, .inc_i, .dec_i,
    .start_i, .stop_i, .load_i, .cmp_i, .count_o, .test_o, .ovf_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic check_all(input string req);
    for (int u = 0; u < N; u++) begin
      chk(req, int'(count_o[u]), m_cnt[u]);
      chk(req, int'(ovf_o[u]), int'(m_ovf[u]));
      chk(req, int'(test_o[u]), int'(m_cnt[u] >= int'(cmp_i[u])));
    end
  endtask

  // Advance one edge; the expected state is derived from the stated rules.
  task automatic tick(input string req);
    int nc [N];
    bit nr [N];
    bit no [N];
    for (int u = 0; u < N; u++) begin
      nc[u] = m_cnt[u]; nr[u] = m_run[u]; no[u] = m_ovf[u];
      if (clr_i[u]) begin
        nc[u] = 0; no[u] = 1'b0;
      end else if (set_i[u]) begin
        nc[u] = int'(load_i[u]);
      end else if (!mode_i[u]) begin
        if (inc_i[u]) begin
          if (nc[u] == MAXV) no[u] = 1'b1; else nc[u]++;
        end else if (dec_i[u]) begin
          if (nc[u] == 0) no[u] = 1'b1; else nc[u]--;
        end
      end else begin
        if (m_run[u]) begin
          if (nc[u] == MAXV) no[u] = 1'b1; else nc[u]++;
        end
        if (stop_i[u]) nr[u] = 1'b0;
        else if (start_i[u]) nr[u] = 1'b1;
      end
    end
    @(posedge clk);
    #2;
    for (int u = 0; u < N; u++) begin
      m_cnt[u] = nc[u]; m_run[u] = nr[u]; m_ovf[u] = no[u];
    end
    clr_i = '0; set_i = '0; inc_i = '0; dec_i = '0; start_i = '0; stop_i = '0;
    #1;
    check_all(req);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    finish_up();
  end

  initial begin
    for (int u = 0; u < N; u++) begin m_cnt[u] = 0; m_run[u] = 0; m_ovf[u] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R1");
    cmp_i[1] = W'(5);
    #1;
    chk("R1", int'(test_o[1]), 0);
    cmp_i[1] = '0;

    // R2 and R4: full upward walk on unit 0, one step past the top.
    for (int i = 0; i <= MAXV; i++) begin
      inc_i[0] = 1'b1;
      tick("R2");
    end
    chk("R4", int'(count_o[0]), MAXV);
    chk("R4", int'(ovf_o[0]), 1);
    chk("R10", int'(count_o[1]), 0);
    // R4 sticky through a down step, then a clear drops it
    dec_i[0] = 1'b1; tick("R4");
    chk("R4", int'(ovf_o[0]), 1);
    clr_i[0] = 1'b1; tick("R6");
    // R2 start/stop ignored in counting mode
    start_i[0] = 1'b1; tick("R2");
    tick("R2");
    // R4 downward walk on unit 1 from the top, one past zero
    set_i[1] = 1'b1; load_i[1] = W'(MAXV); tick("R8");
    for (int i = 0; i <= MAXV; i++) begin
      dec_i[1] = 1'b1;
      tick("R4");
    end
    chk("R4", int'(ovf_o[1]), 1);

    // R5: every count against every threshold
    for (int v = 0; v <= MAXV; v++) begin
      set_i[0] = 1'b1; load_i[0] = W'(v); tick("R8");
      for (int c = 0; c <= MAXV; c++) begin
        cmp_i[0] = W'(c);
        #1;
        chk("R5", int'(test_o[0]), int'(v >= c));
      end
    end
    cmp_i[0] = W'(3);

    // R6: clear is seen before the edge
    set_i[0] = 1'b1; load_i[0] = W'(9); tick("R8");
    clr_i[0] = 1'b1;
    #1;
    chk("R6", int'(count_o[0]), 0);
    chk("R6", int'(test_o[0]), 0);
    tick("R6");

    // R3: timer start, run, stop
    mode_i[0] = 1'b1;
    inc_i[0] = 1'b1; tick("R3");
    start_i[0] = 1'b1; tick("R3");
    chk("R3", int'(count_o[0]), 0);
    repeat (4) tick("R3");
    chk("R3", int'(count_o[0]), 4);
    // R7: clear while running keeps it running
    clr_i[0] = 1'b1; tick("R7");
    repeat (3) tick("R7");
    chk("R7", int'(count_o[0]), 3);
    // R8: load while running keeps it running
    set_i[0] = 1'b1; load_i[0] = W'(13); tick("R8");
    tick("R8");
    chk("R8", int'(count_o[0]), 14);
    // R4: timer saturation
    repeat (3) tick("R4");
    chk("R4", int'(ovf_o[0]), 1);
    stop_i[0] = 1'b1; tick("R3");
    repeat (2) tick("R3");
    // R7: clear while halted stays at zero
    clr_i[0] = 1'b1; tick("R7");
    repeat (3) tick("R7");
    chk("R7", int'(count_o[0]), 0);

    // R9: coinciding commands
    start_i[0] = 1'b1; stop_i[0] = 1'b1; tick("R9");
    tick("R9");
    set_i[0] = 1'b1; start_i[0] = 1'b1; load_i[0] = W'(2); tick("R9");
    tick("R9");
    chk("R9", int'(count_o[0]), 2);
    clr_i[1] = 1'b1; set_i[1] = 1'b1; load_i[1] = W'(7); tick("R9");
    chk("R9", int'(count_o[1]), 0);
    set_i[1] = 1'b1; inc_i[1] = 1'b1; load_i[1] = W'(7); tick("R9");
    chk("R9", int'(count_o[1]), 7);
    inc_i[1] = 1'b1; dec_i[1] = 1'b1; tick("R9");
    chk("R9", int'(count_o[1]), 8);
    // R10: unit 0 untouched by unit 1 traffic
    chk("R10", int'(count_o[0]), 2);

    finish_up();
  end

endmodule